// File: doc/BRIEF.md
# ADC Threshold-Compare Wake-Up Unit

This block sits behind an 8-bit analog-to-digital converter and turns each finished sample into an interrupt decision. Software programs a control register and a threshold over a small register bus. Each time the converter pulses its done strobe, the block latches the sample and compares it with the threshold. The comparison is either "sample at or above threshold" or "sample below threshold". A match sets a sticky interrupt flag. While the core is halted, that flag also drives a wake-up output.

The first accepted sample after the converter start level rises is treated as unreliable. It is latched, but it never raises the interrupt. A halt-repeat bit decides whether samples taken during halt are used. With the bit clear, samples that arrive in halt are dropped. With the bit set, they are latched and compared. Setting the bit outside halt is a misuse: the block raises a flag for it and drops the samples that arrive in that state.

Top module: `adc_cmp_wake`

## Requirements
- R1: After reset, every register reads 0x00 (control, threshold, status, result) and the `irq`, `wake` and `misuse` outputs are low.
- R2: Register map by `reg_addr`: 0 is control, 1 is threshold (read/write, bit 7 MSB), 2 is status, 3 is result (read-only; writes have no effect). Control bit 7 enables comparison, bit 6 selects the condition, bit 5 enables halt-repeat, and bits 4..0 read 0. Status bit 0 is the interrupt flag and bits 7..1 read 0.
- R3: With compare enabled and control bit 6 = 0, an accepted non-first sample sets the flag when sample >= threshold, so equality counts as a match. A smaller sample leaves the flag unchanged.
- R4: With compare enabled and control bit 6 = 1, an accepted non-first sample sets the flag when sample < threshold. An equal or larger sample does not.
- R5: With compare disabled (control bit 7 = 0), every accepted non-first sample sets the flag, whatever its value.
- R6: The first accepted sample after `start_lvl` rises is latched into the result register but never sets the flag.
- R7: While `halt` is high and halt-repeat is clear, a done strobe changes neither the result nor the flag.
- R8: While `halt` is high and halt-repeat is set, samples are latched and compared. `wake` is high exactly when the flag is set and `halt` is high.
- R9: While `halt` is low and halt-repeat is set, `misuse` is high and a done strobe changes neither the result nor the flag.
- R10: The flag is sticky. Writing status with bit 0 = 0 clears it, and writing bit 0 = 1 has no effect. A match in the same cycle as a clear leaves the flag set.
- R11: A done strobe while `start_lvl` is low is ignored: the result and the flag are unchanged.
- R12: A sample accepted on the clock edge that samples the done strobe updates the flag and the result right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| start_lvl | input | 1 | Converter start level from the CPU |
| halt | input | 1 | Core is in the low-power halt state |
| conv_done | input | 1 | One-cycle strobe: a conversion finished |
| conv_data | input | 8 | Sample that goes with `conv_done` |
| irq | output | 1 | Sticky interrupt request |
| wake | output | 1 | Wake-up request while halted |
| misuse | output | 1 | Halt-repeat is set while the core is running |

## Verification
The bench targets these corner cases:
- Equality at the threshold. A design that swaps `>=` for `>` would miss the match, and one that makes the below-threshold test inclusive would raise a spurious interrupt.
- The first sample after each rise of the start level. A design that forgets to suppress it, or that suppresses the wrong sample, raises or loses an interrupt one conversion off.
- A clear and a match in the same cycle. A design with the wrong priority drops a real event.
- Each combination of halt and halt-repeat. A design that ignores the halt gate would latch results it must drop, and would either stay asleep or wake without cause.

// File: rtl/adc_cmp_pkg.sv
package adc_cmp_pkg;
    localparam int CTRL_EN_BIT   = 7;
    localparam int CTRL_COND_BIT = 6;
    localparam int CTRL_HREP_BIT = 5;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_THR  = 2'd1;
    localparam logic [1:0] A_STAT = 2'd2;
    localparam logic [1:0] A_RES  = 2'd3;

    typedef struct packed {
        logic en;
        logic cond_lt;
        logic hrep;
    } ctrl_t;
endpackage

// File: rtl/adc_cmp_regs.sv
module adc_cmp_regs
    import adc_cmp_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    addr,
    input  logic [DW-1:0] wdata,
    output ctrl_t         ctrl,
    output logic [DW-1:0] thr,
    output logic          irq_clr
);
    typedef struct packed {
        ctrl_t         ctrl;
        logic [DW-1:0] thr;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en && addr == A_CTRL) begin
            r_d.ctrl.en      = wdata[CTRL_EN_BIT];
            r_d.ctrl.cond_lt = wdata[CTRL_COND_BIT];
            r_d.ctrl.hrep    = wdata[CTRL_HREP_BIT];
        end
        if (wr_en && addr == A_THR) begin
            r_d.thr = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ctrl    = r_q.ctrl;
    assign thr     = r_q.thr;
    assign irq_clr = wr_en && (addr == A_STAT) && !wdata[0];
endmodule

// File: rtl/adc_cmp_judge.sv
module adc_cmp_judge #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] sample,
    input  logic [DW-1:0] thr,
    input  logic          en,
    input  logic          cond_lt,
    output logic          hit
);
    logic below;
    assign below = (sample < thr);

    always_comb begin
        if (!en)         hit = 1'b1;
        else if (cond_lt) hit = below;
        else             hit = !below;
    end
endmodule

// File: rtl/adc_cmp_core.sv
module adc_cmp_core
    import adc_cmp_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ctrl_t         ctrl,
    input  logic [DW-1:0] thr,
    input  logic          irq_clr,
    input  logic          start_lvl,
    input  logic          halt,
    input  logic          conv_done,
    input  logic [DW-1:0] conv_data,
    output logic [DW-1:0] result,
    output logic          irq,
    output logic          accept
);
    typedef struct packed {
        logic          start_prev;
        logic          first;
        logic [DW-1:0] result;
        logic          irq;
    } core_t;

    core_t c_d, c_q;
    logic  hit, start_rise, first_now, mode_ok, set_irq;

    adc_cmp_judge #(.DW(DW)) u_judge (
        .sample  (conv_data),
        .thr     (thr),
        .en      (ctrl.en),
        .cond_lt (ctrl.cond_lt),
        .hit     (hit)
    );

    always_comb begin
        start_rise = start_lvl && !c_q.start_prev;
        first_now  = c_q.first || start_rise;
        mode_ok    = halt ? ctrl.hrep : !ctrl.hrep;
        accept     = conv_done && start_lvl && mode_ok;
        set_irq    = accept && !first_now && hit;

        c_d            = c_q;
        c_d.start_prev = start_lvl;
        c_d.first      = accept ? 1'b0 : first_now;
        if (accept) c_d.result = conv_data;
        c_d.irq        = set_irq || (c_q.irq && !irq_clr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign result = c_q.result;
    assign irq    = c_q.irq;
endmodule

// File: rtl/adc_cmp_wake.sv
module adc_cmp_wake
    import adc_cmp_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          start_lvl,
    input  logic          halt,
    input  logic          conv_done,
    input  logic [DW-1:0] conv_data,
    output logic          irq,
    output logic          wake,
    output logic          misuse
);
    ctrl_t         ctrl;
    logic [DW-1:0] thr;
    logic [DW-1:0] result;
    logic          irq_clr;
    logic          accept;

    adc_cmp_regs #(.DW(DW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .ctrl    (ctrl),
        .thr     (thr),
        .irq_clr (irq_clr)
    );

    adc_cmp_core #(.DW(DW)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl      (ctrl),
        .thr       (thr),
        .irq_clr   (irq_clr),
        .start_lvl (start_lvl),
        .halt      (halt),
        .conv_done (conv_done),
        .conv_data (conv_data),
        .result    (result),
        .irq       (irq),
        .accept    (accept)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: begin
                reg_rdata[CTRL_EN_BIT]   = ctrl.en;
                reg_rdata[CTRL_COND_BIT] = ctrl.cond_lt;
                reg_rdata[CTRL_HREP_BIT] = ctrl.hrep;
            end
            A_THR:   reg_rdata    = thr;
            A_STAT:  reg_rdata[0] = irq;
            default: reg_rdata    = result;
        endcase
    end

    assign wake   = irq && halt;
    assign misuse = ctrl.hrep && !halt;
endmodule

// File: rtl/adc_cmp_checker.sv
module adc_cmp_checker #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          halt,
    input logic          hrep,
    input logic          start_lvl,
    input logic          conv_done,
    input logic          irq,
    input logic          irq_clr,
    input logic          accept,
    input logic [DW-1:0] result
);
    p_halt_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !hrep && !irq) |=> !irq);
    p_halt_res_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !hrep) |=> $stable(result));
    p_misuse_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt && hrep && !irq) |=> !irq);
    p_misuse_res_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt && hrep) |=> $stable(result));
    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);
    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !accept) |=> !irq);
    p_start_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_lvl && !irq) |=> (!irq && $stable(result)));
    p_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(start_lvl) && !irq) |=> !irq);
endmodule

bind adc_cmp_wake adc_cmp_checker #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .halt      (halt),
    .hrep      (ctrl.hrep),
    .start_lvl (start_lvl),
    .conv_done (conv_done),
    .irq       (irq),
    .irq_clr   (irq_clr),
    .accept    (accept),
    .result    (result)
);

// File: tb/sim_adc_cmp_wake.sv
module sim_adc_cmp_wake;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       start_lvl = 1'b0;
    logic       halt = 1'b0;
    logic       conv_done = 1'b0;
    logic [7:0] conv_data = 8'd0;
    logic       irq, wake, misuse;

    int checks = 0;
    int errors = 0;

    // reference state
    logic       m_en = 0, m_cond = 0, m_hrep = 0;
    logic [7:0] m_thr = 0, m_res = 0;
    logic       m_irq = 0, m_first = 0, m_prev = 0;

    always #2 clk = ~clk;

    adc_cmp_wake u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .start_lvl(start_lvl),
        .halt(halt), .conv_done(conv_done), .conv_data(conv_data),
        .irq(irq), .wake(wake), .misuse(misuse)
    );

    function automatic logic f_hit(logic en, logic cond, logic [7:0] s, logic [7:0] t);
        if (!en) return 1'b1;
        return cond ? (s < t) : (s >= t);
    endfunction

    function automatic logic [7:0] f_read(logic [1:0] a);
        case (a)
            2'd0:    return {m_en, m_cond, m_hrep, 5'b0};
            2'd1:    return m_thr;
            2'd2:    return {7'b0, m_irq};
            default: return m_res;
        endcase
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(string tag, logic wr, logic [1:0] a, logic [7:0] wd,
                       logic st, logic hl, logic dn, logic [7:0] dd);
        logic rise, first_now, ok, acc, clr;
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = wd;
        start_lvl = st; halt = hl; conv_done = dn; conv_data = dd;
        rise      = st && !m_prev;
        first_now = m_first || rise;
        ok        = hl ? m_hrep : !m_hrep;
        acc       = dn && st && ok;
        clr       = wr && a == 2'd2 && !wd[0];
        m_irq     = (acc && !first_now && f_hit(m_en, m_cond, dd, m_thr)) || (m_irq && !clr);
        m_first   = acc ? 1'b0 : first_now;
        m_prev    = st;
        if (acc) m_res = dd;
        if (wr && a == 2'd0) begin m_en = wd[7]; m_cond = wd[6]; m_hrep = wd[5]; end
        if (wr && a == 2'd1) m_thr = wd;
        @(posedge clk);
        #1;
        chk({tag, " irq"}, {7'b0, irq}, {7'b0, m_irq});
        chk({tag, " wake"}, {7'b0, wake}, {7'b0, m_irq && hl});
        chk({tag, " misuse"}, {7'b0, misuse}, {7'b0, m_hrep && !hl});
        chk({tag, " rdata"}, reg_rdata, f_read(a));
    endtask

    initial begin
        #400000;
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        for (int a = 0; a < 4; a++) begin
            reg_addr = a[1:0]; #0.1;
            chk("R1 reset reg", reg_rdata, 8'h00);
        end
        chk("R1 reset pins", {5'b0, irq, wake, misuse}, 8'h00);
        @(negedge clk); rst_n = 1'b1;

        // R2 register map
        cyc("R2 ctrl", 1, 2'd0, 8'hFF, 0, 0, 0, 0);
        cyc("R2 ctrl rd", 0, 2'd0, 0, 0, 0, 0, 0);
        cyc("R2 thr", 1, 2'd1, 8'h80, 0, 0, 0, 0);
        cyc("R2 res ro", 1, 2'd3, 8'h55, 0, 0, 0, 0);
        cyc("R2 stat", 0, 2'd2, 0, 0, 0, 0, 0);
        cyc("R3 ctrl", 1, 2'd0, 8'h80, 0, 0, 0, 0);
        // R6 first sample after rise
        cyc("R6 first", 0, 2'd3, 0, 1, 0, 1, 8'h90);
        cyc("R6 read", 0, 2'd2, 0, 1, 0, 0, 0);
        // R3 >= threshold, R12 timing
        cyc("R3 above R12", 0, 2'd2, 0, 1, 0, 1, 8'h90);
        cyc("R10 clr", 1, 2'd2, 8'h00, 1, 0, 0, 0);
        cyc("R3 below", 0, 2'd3, 0, 1, 0, 1, 8'h7F);
        cyc("R3 equal", 0, 2'd3, 0, 1, 0, 1, 8'h80);
        // R10 same-cycle clear and match; write 1
        cyc("R10 clr+hit", 1, 2'd2, 8'h00, 1, 0, 1, 8'hFF);
        cyc("R10 write1", 1, 2'd2, 8'h01, 1, 0, 0, 0);
        cyc("R10 clr", 1, 2'd2, 8'hFE, 1, 0, 0, 0);
        // R4 below
        cyc("R4 ctrl", 1, 2'd0, 8'hC0, 1, 0, 0, 0);
        cyc("R4 equal", 0, 2'd2, 0, 1, 0, 1, 8'h80);
        cyc("R4 below", 0, 2'd2, 0, 1, 0, 1, 8'h7F);
        cyc("R4 clr", 1, 2'd2, 8'h00, 1, 0, 0, 0);
        // R5 compare off
        cyc("R5 ctrl", 1, 2'd0, 8'h40, 1, 0, 0, 0);
        cyc("R5 any", 0, 2'd2, 0, 1, 0, 1, 8'hF0);
        cyc("R5 clr", 1, 2'd2, 8'h00, 1, 0, 0, 0);
        // R7 halt without repeat
        cyc("R7 ctrl", 1, 2'd0, 8'h80, 1, 1, 0, 0);
        cyc("R7 halt", 0, 2'd3, 0, 1, 1, 1, 8'h11);
        // R8 halt with repeat
        cyc("R8 ctrl", 1, 2'd0, 8'hA0, 1, 1, 0, 0);
        cyc("R8 halt", 0, 2'd3, 0, 1, 1, 1, 8'hC3);
        cyc("R8 clr", 1, 2'd2, 8'h00, 1, 1, 0, 0);
        // R9 misuse outside halt
        cyc("R9 run", 0, 2'd3, 0, 1, 0, 1, 8'hEE);
        cyc("R9 ctrl", 1, 2'd0, 8'h80, 1, 0, 0, 0);
        // R11 start low, then R6 re-arm
        cyc("R11 low", 0, 2'd3, 0, 0, 0, 1, 8'h99);
        cyc("R6 rearm", 0, 2'd2, 0, 1, 0, 1, 8'hFF);
        cyc("R6 after", 0, 2'd2, 0, 1, 0, 1, 8'hFF);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic wr;
            wr = ($urandom % 8) == 0;
            cyc("R3 R4 R5 R8 R10 rnd", wr, 2'($urandom), 8'($urandom),
                ($urandom % 10) != 0, ($urandom % 3) == 0,
                ($urandom % 2) == 0, 8'($urandom));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule